// File: doc/BRIEF.md
# Vector Operand Swizzle and Write-Mask Stage

This stage sits between the register storage and the arithmetic units of a four-lane vector shader datapath. On the read side it takes the nominal register number of one source operand and may add a relative index to it. It drives the resulting address to the register storage. The vector that comes back is reordered lane by lane under an 8-bit selector, may have its sign flipped, and is held in an output register for the arithmetic units. Lanes are opaque words, and only the most significant bit of each is treated as a sign. Lane x sits in the lowest bits of a packed vector, then y, then z, with w in the highest bits.

On the write side the stage merges a finished result into the current contents of the destination register under a 4-bit lane mask. The merged vector goes back to the storage in the same cycle.

Top module: `vec_operand_stage`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_vec` is all zeros until the first accepted read.
- R2: Output lane x takes the source lane named by selector bits [7:6], y by [5:4], z by [3:2] and w by [1:0], where the codes 0, 1, 2 and 3 name source lanes x, y, z and w.
- R3: A selector of 0x1B with negation off passes the fetched vector through unchanged.
- R4: `rd_neg` holds one flag per operand: bit 0 for operand 1, bit 1 for operand 2 and bit 2 for operand 3. The flag of the operand named by `rd_slot` inverts the top bit of all four lanes after the reorder. The flags of the other operands have no effect.
- R5: The relative index code `rd_rel` adds 0 for code 0, `idx_ax` for code 1, `idx_ay` for code 2 and `idx_loop` for code 3 to the register number. Each index is a two's-complement value.
- R6: The index is added only for one operand. In the two-source form this is operand 1, or operand 2 when `rd_inv` is set. In the three-source form (`rd_mad` set) it is operand 2, or operand 3 when `rd_inv` is set. Every other operand uses `rd_reg` directly.
- R7: An indexed register number outside the file wraps modulo the file size, which is 2^REG_AW.
- R8: Write mask bit 3 enables lane x, bit 2 lane y, bit 1 lane z and bit 0 lane w. An enabled lane of `wr_data` equals the same lane of `wr_result`, so a mask of 0xF yields the whole result.
- R9: A lane whose mask bit is 0 keeps the same lane of `wr_old`.
- R10: `out_valid` is `rd_valid` delayed by one clock. `out_vec` is updated only after a cycle with `rd_valid` high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | An operand read is presented this cycle |
| rd_slot | input | 2 | Operand number, 1 to 3 |
| rd_mad | input | 1 | Three-source instruction form |
| rd_inv | input | 1 | Inverted operand form |
| rd_reg | input | REG_AW | Nominal source register number |
| rd_rel | input | 2 | Relative index code |
| idx_ax | input | IDX_W | First address index, signed |
| idx_ay | input | IDX_W | Second address index, signed |
| idx_loop | input | IDX_W | Loop counter index, signed |
| rd_sel | input | 8 | Lane selector |
| rd_neg | input | 3 | Per-operand negate flags |
| rd_addr | output | REG_AW | Effective register address to storage |
| rd_data | input | 4*WORD_W | Vector read back from storage at rd_addr |
| out_valid | output | 1 | out_vec carries a new operand |
| out_vec | output | 4*WORD_W | Reordered, sign-adjusted operand |
| wr_mask | input | 4 | Destination lane enables |
| wr_result | input | 4*WORD_W | New result vector |
| wr_old | input | 4*WORD_W | Current destination contents |
| wr_data | output | 4*WORD_W | Merged vector to write back |

## Verification
The assertions check on every cycle that lanes are merged lane by lane under the mask, and that the read address falls back to the plain register number whenever no index applies. They also check the valid delay, the pass-through with the identity selector, and the sign flip under that selector. Only the bench scenarios show the lane order for arbitrary selectors, the index arithmetic with negative indices and wrap-around, and the fact that negate flags of other operands have no effect. For these the bench compares each output against its own model of the storage and of the index rules.

// File: rtl/vec_operand_stage.sv
module vec_operand_stage #(
  parameter int WORD_W = 24,
  parameter int REG_AW = 4,
  parameter int IDX_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_valid,
  input  logic [1:0]            rd_slot,
  input  logic                  rd_mad,
  input  logic                  rd_inv,
  input  logic [REG_AW-1:0]     rd_reg,
  input  logic [1:0]            rd_rel,
  input  logic [IDX_W-1:0]      idx_ax,
  input  logic [IDX_W-1:0]      idx_ay,
  input  logic [IDX_W-1:0]      idx_loop,
  input  logic [7:0]            rd_sel,
  input  logic [2:0]            rd_neg,
  output logic [REG_AW-1:0]     rd_addr,
  input  logic [4*WORD_W-1:0]   rd_data,
  output logic                  out_valid,
  output logic [4*WORD_W-1:0]   out_vec,
  input  logic [3:0]            wr_mask,
  input  logic [4*WORD_W-1:0]   wr_result,
  input  logic [4*WORD_W-1:0]   wr_old,
  output logic [4*WORD_W-1:0]   wr_data
);
  localparam int VEC_W = 4 * WORD_W;

  logic [1:0]       off_slot;
  logic             rel_on;
  logic [IDX_W-1:0] offs;
  logic             neg_on;
  logic [VEC_W-1:0] swz;

  assign off_slot = rd_mad ? (rd_inv ? 2'd3 : 2'd2) : (rd_inv ? 2'd2 : 2'd1);
  assign rel_on   = (rd_slot == off_slot) && (rd_rel != 2'd0);

  always_comb begin
    case (rd_rel)
      2'd1:    offs = idx_ax;
      2'd2:    offs = idx_ay;
      2'd3:    offs = idx_loop;
      default: offs = '0;
    endcase
  end

  assign rd_addr = rel_on ? rd_reg + offs[REG_AW-1:0] : rd_reg;
  assign neg_on  = (rd_slot != 2'd0) && rd_neg[rd_slot - 2'd1];

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [1:0] pick;
    assign pick = rd_sel[7-2*i -: 2];
    assign swz[i*WORD_W +: WORD_W] =
      rd_data[pick*WORD_W +: WORD_W] ^ {neg_on, {(WORD_W-1){1'b0}}};
    assign wr_data[i*WORD_W +: WORD_W] =
      wr_mask[3-i] ? wr_result[i*WORD_W +: WORD_W] : wr_old[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= rd_valid;
      if (rd_valid) out_vec <= swz;
    end
  end
endmodule

// File: rtl/vec_operand_stage_chk.sv
module vec_operand_stage_chk #(
  parameter int WORD_W = 24,
  parameter int REG_AW = 4,
  parameter int IDX_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_valid,
  input logic [1:0]          rd_slot,
  input logic                rd_mad,
  input logic                rd_inv,
  input logic [REG_AW-1:0]   rd_reg,
  input logic [1:0]          rd_rel,
  input logic [7:0]          rd_sel,
  input logic [2:0]          rd_neg,
  input logic [REG_AW-1:0]   rd_addr,
  input logic [4*WORD_W-1:0] rd_data,
  input logic                out_valid,
  input logic [4*WORD_W-1:0] out_vec,
  input logic [3:0]          wr_mask,
  input logic [4*WORD_W-1:0] wr_result,
  input logic [4*WORD_W-1:0] wr_old,
  input logic [4*WORD_W-1:0] wr_data
);
  localparam int W = WORD_W;
  localparam logic [4*WORD_W-1:0] SIGNS =
    {4{1'b1, {(WORD_W-1){1'b0}}}};

  logic idx_slot;
  assign idx_slot = rd_mad ? (rd_slot == (rd_inv ? 2'd3 : 2'd2))
                           : (rd_slot == (rd_inv ? 2'd2 : 2'd1));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid && out_vec == '0);

  a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !out_valid && $stable(out_vec));

  a_r3_identity: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_sel == 8'h1B && rd_neg == 3'b000 |=> out_vec == $past(rd_data));

  a_r4_negate: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_sel == 8'h1B && rd_slot == 2'd1 && rd_neg == 3'b001
      |=> out_vec == ($past(rd_data) ^ SIGNS));

  a_r5_no_index: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rel == 2'd0 |-> rd_addr == rd_reg);

  a_r6_other_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_slot |-> rd_addr == rd_reg);

  a_r8_take_new: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mask[3] || wr_data[0*W +: W] == wr_result[0*W +: W]) &&
    (!wr_mask[2] || wr_data[1*W +: W] == wr_result[1*W +: W]) &&
    (!wr_mask[1] || wr_data[2*W +: W] == wr_result[2*W +: W]) &&
    (!wr_mask[0] || wr_data[3*W +: W] == wr_result[3*W +: W]));

  a_r9_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask[3] || wr_data[0*W +: W] == wr_old[0*W +: W]) &&
    (wr_mask[2] || wr_data[1*W +: W] == wr_old[1*W +: W]) &&
    (wr_mask[1] || wr_data[2*W +: W] == wr_old[2*W +: W]) &&
    (wr_mask[0] || wr_data[3*W +: W] == wr_old[3*W +: W]));
endmodule

bind vec_operand_stage vec_operand_stage_chk #(
  .WORD_W(WORD_W), .REG_AW(REG_AW), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/vec_operand_stage_tb.sv
module vec_operand_stage_tb;
  localparam int W  = 24;
  localparam int AW = 4;
  localparam int IW = 8;
  localparam int N  = 1 << AW;
  localparam int VW = 4 * W;

  logic clk = 0;
  logic rst_n = 0;
  logic rd_valid = 0;
  logic [1:0] rd_slot = 2'd1;
  logic rd_mad = 0, rd_inv = 0;
  logic [AW-1:0] rd_reg = '0;
  logic [1:0] rd_rel = '0;
  logic [IW-1:0] idx_ax = '0, idx_ay = '0, idx_loop = '0;
  logic [7:0] rd_sel = 8'h1B;
  logic [2:0] rd_neg = '0;
  logic [AW-1:0] rd_addr;
  logic [VW-1:0] rd_data;
  logic out_valid;
  logic [VW-1:0] out_vec;
  logic [3:0] wr_mask = '0;
  logic [VW-1:0] wr_result = '0, wr_old = '0;
  logic [VW-1:0] wr_data;

  logic [VW-1:0] mem [N];
  logic [VW-1:0] exp_vec;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign rd_data = mem[rd_addr];

  vec_operand_stage #(.WORD_W(W), .REG_AW(AW), .IDX_W(IW)) u_dut (.*);

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] lane(logic [VW-1:0] v, int k);
    return v[k*W +: W];
  endfunction

  task automatic rd(string tag, int slot, bit mad, bit inv, int rg, int rel,
                    int ax, int ay, int lc, logic [7:0] sel, logic [2:0] neg);
    int e;
    int flag;
    bit applies;
    logic [VW-1:0] src;
    @(negedge clk);
    rd_valid = 1; rd_slot = 2'(slot); rd_mad = mad; rd_inv = inv;
    rd_reg = AW'(rg); rd_rel = 2'(rel);
    idx_ax = IW'(ax); idx_ay = IW'(ay); idx_loop = IW'(lc);
    rd_sel = sel; rd_neg = neg;
    if (mad) applies = (slot == (inv ? 3 : 2));
    else     applies = (slot == (inv ? 2 : 1));
    e = rg;
    if (applies && rel == 1) e += ax;
    if (applies && rel == 2) e += ay;
    if (applies && rel == 3) e += lc;
    e = ((e % N) + N) % N;
    src = mem[e];
    flag = neg[slot-1];
    for (int k = 0; k < 4; k++) begin
      int pick;
      pick = sel[7-2*k] * 2 + sel[6-2*k];
      exp_vec[k*W +: W] = lane(src, pick);
      if (flag != 0) exp_vec[k*W + W - 1] = ~exp_vec[k*W + W - 1];
    end
    #1 chk({tag, " addr"}, VW'(rd_addr), VW'(e));
    @(negedge clk);
    chk({tag, " valid"}, VW'(out_valid), VW'(1));
    chk({tag, " data"}, out_vec, exp_vec);
  endtask

  task automatic wr(string tag, logic [3:0] m, logic [VW-1:0] res, logic [VW-1:0] old);
    logic [VW-1:0] e;
    @(negedge clk);
    wr_mask = m; wr_result = res; wr_old = old;
    for (int k = 0; k < 4; k++)
      e[k*W +: W] = m[3-k] ? res[k*W +: W] : old[k*W +: W];
    #1 chk(tag, wr_data, e);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++)
      for (int k = 0; k < 4; k++)
        mem[r][k*W +: W] = W'((r << 12) | ((k + 1) << 4) | (r[0] ? 32'h800000 : 0) | 3);
    repeat (3) @(negedge clk);
    chk("R1 reset valid", VW'(out_valid), VW'(0));
    chk("R1 reset data", out_vec, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", VW'(out_valid), VW'(0));

    rd("R3 identity", 1, 0, 0, 5, 0, 0, 0, 0, 8'h1B, 3'b000);
    rd("R2 reverse", 1, 0, 0, 6, 0, 0, 0, 0, 8'hE4, 3'b000);
    rd("R2 broadcast x", 2, 0, 0, 7, 0, 0, 0, 0, 8'h00, 3'b000);
    rd("R2 broadcast w", 3, 1, 0, 9, 0, 0, 0, 0, 8'hFF, 3'b000);
    rd("R2 mixed", 1, 0, 0, 2, 0, 0, 0, 0, 8'h9C, 3'b000);
    rd("R4 negate op2", 2, 0, 0, 3, 0, 0, 0, 0, 8'h1B, 3'b010);
    rd("R4 other flags", 1, 0, 0, 3, 0, 0, 0, 0, 8'h1B, 3'b110);
    rd("R4 negate op3 swz", 3, 1, 0, 4, 0, 0, 0, 0, 8'h4E, 3'b100);
    rd("R5 index ax", 1, 0, 0, 2, 1, 3, 5, 7, 8'h1B, 3'b000);
    rd("R5 index ay", 1, 0, 0, 2, 2, 3, 5, 7, 8'h1B, 3'b000);
    rd("R5 index loop", 1, 0, 0, 2, 3, 3, 5, 7, 8'h1B, 3'b000);
    rd("R6 two-src op2 plain", 2, 0, 0, 2, 1, 3, 0, 0, 8'h1B, 3'b000);
    rd("R6 two-src inv op2", 2, 0, 1, 2, 1, 3, 0, 0, 8'h1B, 3'b000);
    rd("R6 two-src inv op1", 1, 0, 1, 2, 1, 3, 0, 0, 8'h1B, 3'b000);
    rd("R6 three-src op2", 2, 1, 0, 2, 2, 0, 4, 0, 8'h1B, 3'b000);
    rd("R6 three-src op1", 1, 1, 0, 2, 2, 0, 4, 0, 8'h1B, 3'b000);
    rd("R6 three-src inv op3", 3, 1, 1, 2, 3, 0, 0, 6, 8'h1B, 3'b000);
    rd("R6 three-src inv op2", 2, 1, 1, 2, 3, 0, 0, 6, 8'h1B, 3'b000);
    rd("R7 wrap up", 1, 0, 0, 14, 1, 5, 0, 0, 8'h1B, 3'b000);
    rd("R7 wrap down", 1, 0, 0, 1, 2, 0, -3, 0, 8'h1B, 3'b000);

    @(negedge clk);
    rd_valid = 0; rd_reg = AW'(11); rd_sel = 8'h00;
    @(negedge clk);
    chk("R10 idle valid", VW'(out_valid), VW'(0));
    chk("R10 idle hold", out_vec, exp_vec);

    for (int n = 0; n < 40; n++) begin
      int s;
      s = 1 + int'($urandom_range(0, 2));
      rd("R2 mixed random", s, 1'($urandom), 1'($urandom), int'($urandom_range(0, N-1)),
         int'($urandom_range(0, 3)), int'($urandom_range(0, 255)) - 128,
         int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128,
         8'($urandom), 3'($urandom));
    end

    wr("R8 full mask", 4'hF, {4{24'hABCDEF}}, mem[1]);
    wr("R8 x only", 4'h8, {4{24'h123456}}, mem[2]);
    wr("R9 mask zero", 4'h0, {4{24'h777777}}, mem[3]);
    wr("R9 y and w", 4'h5, {24'h444444, 24'h333333, 24'h222222, 24'h111111}, mem[4]);
    wr("R8 z only", 4'h2, {24'h999999, 24'h888888, 24'h666666, 24'h555555}, mem[5]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule